// File: doc/BRIEF.md
# TDM Time-Slot Assigner with Shadow Routing Tables

This block walks a programmable routing table across each frame of a TDM serial link. Every table entry names the serial channel that owns the next slice of the frame, gives the slice length as 1 to 8 bits or 1 to 8 bytes, and lists the strobe outputs to raise during that slice. There is one table for the transmit direction and one for the receive direction. Each direction has its own bit tick and frame sync, and those qualify the system clock. Each table is four banks of 64 sixteen-bit entries.

Software loads entries through a write port. It picks the bank where the link's table begins. It can also name a later bank as a shadow region. While the link runs, software rewrites the idle region and then requests a swap. Each direction exchanges its active and shadow regions at its own next frame sync, so a frame never mixes the two tables. Table contents are undefined after reset and must be written before the link is enabled. The write port is a valid/ready stream. `wr_ready` is held high, so every beat with `wr_valid` high is taken on that clock edge and the block never applies back-pressure.

Top module: `tsa_time_slot_assigner`

## Requirements
- R1: An entry's channel field (bits 3:0), when it is between 1 and 15, raises only bit (field-1) of that direction's channel-enable output.
- R2: An entry's slice lasts (bits 6:4 plus 1) ticks when bit 7 is 0, and 8 times that many ticks when bit 7 is 1. After that the pointer moves to the next entry.
- R3: After the last tick of an entry whose bit 12 is set, the pointer returns to the start of the active region.
- R4: A tick with frame sync high puts the pointer at the start of the active region, with the slice count cleared.
- R5: A channel field of 0 asserts no channel enable and raises that direction's idle output.
- R6: The strobe output is the OR of the current transmit entry's bits 11:8 and the current receive entry's bits 11:8.
- R7: While the link enable is low, all channel enables and strobes are 0, both idle outputs are 1, and both pointers are held at the start of their regions. Ticks during that time have no effect.
- R8: The active region begins at entry index start_bank*64 of each table.
- R9: A swap request with a valid shadow (shadow enabled and shadow bank greater than start bank) sets both pending flags. Each direction exchanges its active and shadow regions at its next enabled sync tick, and its flag then clears.
- R10: The primary region ends before the shadow bank when a shadow is valid, and at the table's top entry otherwise. The shadow region ends at the top entry. The pointer wraps from a region's final entry to the region's start even without bit 12.
- R11: Write address bit 8 selects the table (0 transmit, 1 receive) and bits 7:0 the entry. wr_ready is always 1, so each beat with wr_valid high writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Table write beat valid |
| wr_ready | output | 1 | Write beat accepted (always high) |
| wr_addr | input | 9 | Bit 8 table select, bits 7:0 entry index |
| wr_data | input | 16 | Entry value |
| link_en | input | 1 | Link enable |
| start_bank | input | 2 | First bank of the active region |
| shadow_en | input | 1 | Shadow region enable |
| shadow_bank | input | 2 | First bank of the shadow region |
| swap_req | input | 1 | One-cycle request to exchange regions |
| tx_tick | input | 1 | Transmit bit tick |
| tx_sync | input | 1 | Transmit frame sync, qualified by tx_tick |
| rx_tick | input | 1 | Receive bit tick |
| rx_sync | input | 1 | Receive frame sync, qualified by rx_tick |
| tx_ch_en | output | 15 | Transmit channel enables |
| rx_ch_en | output | 15 | Receive channel enables |
| tx_idle | output | 1 | Transmit slice routed nowhere |
| rx_idle | output | 1 | Receive slice routed nowhere |
| strobe | output | 4 | Combined strobe outputs |
| tx_swap_pend | output | 1 | Transmit swap pending |
| rx_swap_pend | output | 1 | Receive swap pending |

## Verification
The hardest case to reach is a pointer that wraps at the final entry of a region without a last flag. It takes a region filled completely with entries that do not end the table. The bench therefore moves the start bank to the top bank, writes all 64 entries in a loop, and gives only the first entry a distinct channel. It then ticks 64 times and watches that channel come back exactly on the 64th tick. The swap is also hard to reach, because the two directions clear their pending flags at different syncs. The bench ticks each direction's sync on its own and checks one flag clearing while the other is still pending.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int ENTRY_W = 16;
  localparam int CH_W    = 4;
  localparam int STRB_W  = 4;
  localparam int LEN_W   = 3;
  localparam int BYTE_SH = 3;                 // 8 bits per byte unit
  localparam int CNT_W   = LEN_W + BYTE_SH;   // widest slice counter

  typedef struct packed {
    logic [2:0]        rsv;
    logic              last;
    logic [STRB_W-1:0] strb;
    logic              byte_mode;
    logic [LEN_W-1:0]  len_m1;
    logic [CH_W-1:0]   chan;
  } tsa_entry_t;
endpackage

// File: rtl/tsa_route_ram.sv
module tsa_route_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tsa_slot_seq.sv
module tsa_slot_seq
  import tsa_pkg::*;
#(
  parameter int BANKS      = 4,
  parameter int BANK_DEPTH = 64,
  localparam int BW        = $clog2(BANKS),
  localparam int OW        = $clog2(BANK_DEPTH),
  localparam int AW        = BW + OW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_en,
  input  logic [BW-1:0]    start_bank,
  input  logic             shadow_en,
  input  logic [BW-1:0]    shadow_bank,
  input  logic             swap_req,
  input  logic             tick,
  input  logic             sync,
  input  logic             last,
  input  logic             byte_mode,
  input  logic [LEN_W-1:0] len_m1,
  output logic [AW-1:0]    ptr,
  output logic             swap_pend
);
  logic             sel_q;
  logic             shadow_ok;
  logic             next_sel;
  logic             frame_evt;
  logic [BW-1:0]    act_bank;
  logic [BW-1:0]    end_bank;
  logic [BW-1:0]    sync_bank;
  logic [AW-1:0]    cur_base;
  logic [AW-1:0]    cur_end;
  logic [AW-1:0]    sync_base;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_max;

  assign shadow_ok = shadow_en && (shadow_bank > start_bank);
  assign act_bank  = (sel_q && shadow_ok) ? shadow_bank : start_bank;
  assign end_bank  = (shadow_ok && !sel_q) ? (shadow_bank - 1'b1) : BW'(BANKS - 1);
  assign cur_base  = {act_bank, {OW{1'b0}}};
  assign cur_end   = {end_bank, {OW{1'b1}}};

  assign next_sel  = sel_q ^ (swap_pend && shadow_ok);
  assign sync_bank = (next_sel && shadow_ok) ? shadow_bank : start_bank;
  assign sync_base = {sync_bank, {OW{1'b0}}};
  assign frame_evt = link_en && tick && sync;

  assign cnt_max = byte_mode ? {len_m1, {BYTE_SH{1'b1}}}
                             : {{BYTE_SH{1'b0}}, len_m1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      cnt       <= '0;
      sel_q     <= 1'b0;
      swap_pend <= 1'b0;
    end else begin
      if (swap_req && shadow_ok)  swap_pend <= 1'b1;
      else if (frame_evt)         swap_pend <= 1'b0;

      if (!link_en) begin
        ptr <= cur_base;
        cnt <= '0;
      end else if (tick) begin
        if (sync) begin
          sel_q <= next_sel;
          ptr   <= sync_base;
          cnt   <= '0;
        end else if (cnt == cnt_max) begin
          cnt <= '0;
          ptr <= (last || ptr == cur_end) ? cur_base : ptr + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tsa_slot_decode.sv
module tsa_slot_decode
  import tsa_pkg::*;
#(
  parameter int NUM_CH = (1 << CH_W) - 1
) (
  input  logic              link_en,
  input  logic [CH_W-1:0]   chan,
  input  logic [STRB_W-1:0] strb_in,
  output logic [NUM_CH-1:0] ch_en,
  output logic [STRB_W-1:0] strb_out,
  output logic              idle
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_en[c] = link_en && (chan == CH_W'(c + 1));
  end

  assign strb_out = link_en ? strb_in : '0;
  assign idle     = !link_en || (chan == '0);
endmodule

// File: rtl/tsa_time_slot_assigner.sv
module tsa_time_slot_assigner
  import tsa_pkg::*;
#(
  parameter int BANKS      = 4,
  parameter int BANK_DEPTH = 64,
  localparam int DEPTH     = BANKS * BANK_DEPTH,
  localparam int BW        = $clog2(BANKS),
  localparam int AW        = $clog2(DEPTH),
  localparam int NUM_CH    = (1 << CH_W) - 1,
  localparam int NDIR      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW:0]       wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic              link_en,
  input  logic [BW-1:0]     start_bank,
  input  logic              shadow_en,
  input  logic [BW-1:0]     shadow_bank,
  input  logic              swap_req,
  input  logic              tx_tick,
  input  logic              tx_sync,
  input  logic              rx_tick,
  input  logic              rx_sync,
  output logic [NUM_CH-1:0] tx_ch_en,
  output logic [NUM_CH-1:0] rx_ch_en,
  output logic              tx_idle,
  output logic              rx_idle,
  output logic [STRB_W-1:0] strobe,
  output logic              tx_swap_pend,
  output logic              rx_swap_pend
);
  logic              tick_d [NDIR];
  logic              sync_d [NDIR];
  logic [NUM_CH-1:0] en_d   [NDIR];
  logic [STRB_W-1:0] strb_d [NDIR];
  logic              idle_d [NDIR];
  logic              pend_d [NDIR];

  assign wr_ready  = 1'b1;
  assign tick_d[0] = tx_tick;
  assign sync_d[0] = tx_sync;
  assign tick_d[1] = rx_tick;
  assign sync_d[1] = rx_sync;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic          we;
    logic [AW-1:0] ptr;
    tsa_entry_t    entry;

    assign we = wr_valid && wr_ready && (wr_addr[AW] == 1'(d));

    tsa_route_ram #(.DEPTH(DEPTH), .W(ENTRY_W)) i_ram (
      .clk   (clk),
      .we    (we),
      .waddr (wr_addr[AW-1:0]),
      .wdata (wr_data),
      .raddr (ptr),
      .rdata (entry)
    );

    tsa_slot_seq #(.BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_en     (link_en),
      .start_bank  (start_bank),
      .shadow_en   (shadow_en),
      .shadow_bank (shadow_bank),
      .swap_req    (swap_req),
      .tick        (tick_d[d]),
      .sync        (sync_d[d]),
      .last        (entry.last),
      .byte_mode   (entry.byte_mode),
      .len_m1      (entry.len_m1),
      .ptr         (ptr),
      .swap_pend   (pend_d[d])
    );

    tsa_slot_decode #(.NUM_CH(NUM_CH)) i_dec (
      .link_en  (link_en),
      .chan     (entry.chan),
      .strb_in  (entry.strb),
      .ch_en    (en_d[d]),
      .strb_out (strb_d[d]),
      .idle     (idle_d[d])
    );
  end

  assign tx_ch_en     = en_d[0];
  assign rx_ch_en     = en_d[1];
  assign tx_idle      = idle_d[0];
  assign rx_idle      = idle_d[1];
  assign strobe       = strb_d[0] | strb_d[1];
  assign tx_swap_pend = pend_d[0];
  assign rx_swap_pend = pend_d[1];
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker #(
  parameter int NUM_CH = 15,
  parameter int STRB_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              link_en,
  input logic              swap_req,
  input logic              tx_tick,
  input logic              tx_sync,
  input logic              rx_tick,
  input logic              rx_sync,
  input logic [NUM_CH-1:0] tx_ch_en,
  input logic [NUM_CH-1:0] rx_ch_en,
  input logic              tx_idle,
  input logic              rx_idle,
  input logic [STRB_W-1:0] strobe,
  input logic              tx_swap_pend,
  input logic              rx_swap_pend
);
  p_onehot_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_ch_en));
  p_onehot_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_ch_en));

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle |-> tx_ch_en == '0) and (rx_idle |-> rx_ch_en == '0));

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |-> (tx_ch_en == '0 && rx_ch_en == '0 && strobe == '0
                  && tx_idle && rx_idle));

  p_hold_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && !tx_tick && !wr_valid) |=> (!link_en || $stable(tx_ch_en)));

  p_swap_clear_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_swap_pend && link_en && tx_tick && tx_sync && !swap_req) |=> !tx_swap_pend);
  p_swap_clear_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_swap_pend && link_en && rx_tick && rx_sync && !swap_req) |=> !rx_swap_pend);
  p_swap_hold_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_swap_pend && !(link_en && tx_tick && tx_sync)) |=> tx_swap_pend);
endmodule

bind tsa_time_slot_assigner tsa_checker #(.NUM_CH(15), .STRB_W(4)) i_tsa_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .link_en      (link_en),
  .swap_req     (swap_req),
  .tx_tick      (tx_tick),
  .tx_sync      (tx_sync),
  .rx_tick      (rx_tick),
  .rx_sync      (rx_sync),
  .tx_ch_en     (tx_ch_en),
  .rx_ch_en     (rx_ch_en),
  .tx_idle      (tx_idle),
  .rx_idle      (rx_idle),
  .strobe       (strobe),
  .tx_swap_pend (tx_swap_pend),
  .rx_swap_pend (rx_swap_pend)
);

// File: tb/test_tsa_time_slot_assigner.sv
`timescale 1ns/1ps
module test_tsa_time_slot_assigner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [8:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        link_en = 1'b0;
  logic [1:0]  start_bank = 2'd1;
  logic        shadow_en = 1'b0;
  logic [1:0]  shadow_bank = 2'd2;
  logic        swap_req = 1'b0;
  logic        tx_tick = 1'b0, tx_sync = 1'b0, rx_tick = 1'b0, rx_sync = 1'b0;
  logic [14:0] tx_ch_en, rx_ch_en;
  logic        tx_idle, rx_idle, tx_swap_pend, rx_swap_pend;
  logic [3:0]  strobe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tsa_time_slot_assigner i_tsa_time_slot_assigner (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .link_en(link_en),
    .start_bank(start_bank), .shadow_en(shadow_en), .shadow_bank(shadow_bank),
    .swap_req(swap_req), .tx_tick(tx_tick), .tx_sync(tx_sync),
    .rx_tick(rx_tick), .rx_sync(rx_sync), .tx_ch_en(tx_ch_en),
    .rx_ch_en(rx_ch_en), .tx_idle(tx_idle), .rx_idle(rx_idle),
    .strobe(strobe), .tx_swap_pend(tx_swap_pend), .rx_swap_pend(rx_swap_pend)
  );

  // {sync, expected tx_ch_en, expected strobe} after each transmit tick
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 15'h0004, 4'h3}, {1'b0, 15'h0000, 4'h2}, {1'b0, 15'h0010, 4'h6},
    {1'b0, 15'h0010, 4'h6}, {1'b0, 15'h0010, 4'h6}, {1'b0, 15'h0010, 4'h6},
    {1'b0, 15'h0010, 4'h6}, {1'b0, 15'h0010, 4'h6}, {1'b0, 15'h0010, 4'h6},
    {1'b0, 15'h0010, 4'h6}, {1'b0, 15'h0004, 4'h3}, {1'b1, 15'h0004, 4'h3},
    {1'b0, 15'h0004, 4'h3}, {1'b0, 15'h0000, 4'h2}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic tick(input bit rx, input bit sync);
    @(negedge clk);
    if (rx) begin rx_tick = 1'b1; rx_sync = sync; end
    else    begin tx_tick = 1'b1; tx_sync = sync; end
    @(negedge clk);
    tx_tick = 1'b0; tx_sync = 1'b0; rx_tick = 1'b0; rx_sync = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [19:0] v;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(1);
    // R7 / R11: reset state with link disabled
    chk("R7", "tx_ch_en reset", 32'(tx_ch_en), 0);
    chk("R7", "strobe reset", 32'(strobe), 0);
    chk("R7", "idle reset", 32'({tx_idle, rx_idle}), 3);
    chk("R9", "pend reset", 32'({tx_swap_pend, rx_swap_pend}), 0);
    chk("R11", "wr_ready", 32'(wr_ready), 1);

    // R11: tx table at bit8=0, rx table at bit8=1
    wr(9'h040, 16'h0113);   // ch3, 2 bits, strobe0
    wr(9'h041, 16'h0000);   // no channel, 1 bit
    wr(9'h042, 16'h1485);   // ch5, 1 byte, strobe2, last
    wr(9'h080, 16'h1807);   // shadow: ch7, 1 bit, strobe3, last
    wr(9'h140, 16'h1202);   // rx: ch2, strobe1, last
    wr(9'h180, 16'h1009);   // rx shadow: ch9, last
    link_en = 1'b1;
    idle_cycles(1);
    chk("R8", "tx start entry", 32'(tx_ch_en), 32'h4);
    chk("R1", "rx start entry", 32'(rx_ch_en), 32'h2);
    chk("R6", "strobe OR", 32'(strobe), 32'h3);

    // R2 R3 R4 R5 R6: walk the transmit frame
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      tick(1'b0, v[19]);
      chk("R2", $sformatf("vec %0d tx_ch_en", i), 32'(tx_ch_en), 32'(v[18:4]));
      chk("R6", $sformatf("vec %0d strobe", i), 32'(strobe), 32'(v[3:0]));
      chk("R5", $sformatf("vec %0d idle", i), 32'(tx_idle), 32'(v[18:4] == 15'h0));
    end

    // R9: shadow swap
    shadow_en = 1'b1;
    @(negedge clk); swap_req = 1'b1;
    @(negedge clk); swap_req = 1'b0;
    chk("R9", "pend set", 32'({tx_swap_pend, rx_swap_pend}), 3);
    tick(1'b0, 1'b0);
    chk("R9", "no swap before sync", 32'(tx_ch_en), 32'h10);
    chk("R9", "tx pend held", 32'(tx_swap_pend), 1);
    tick(1'b0, 1'b1);
    chk("R9", "tx shadow entry", 32'(tx_ch_en), 32'h40);
    chk("R9", "tx shadow strobe", 32'(strobe), 32'hA);
    chk("R9", "tx pend cleared", 32'({tx_swap_pend, rx_swap_pend}), 1);
    tick(1'b1, 1'b1);
    chk("R9", "rx shadow entry", 32'(rx_ch_en), 32'h100);
    chk("R9", "rx pend cleared", 32'(rx_swap_pend), 0);
    chk("R6", "strobe after rx swap", 32'(strobe), 32'h8);
    @(negedge clk); swap_req = 1'b1;
    @(negedge clk); swap_req = 1'b0;
    tick(1'b0, 1'b1);
    chk("R9", "tx swap back", 32'(tx_ch_en), 32'h4);
    chk("R6", "strobe swap back", 32'(strobe), 32'h1);

    // R7: disabled link ignores ticks, pointers rest at region start
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk("R2", "tx moved before disable", 32'(tx_ch_en), 32'h0);
    link_en = 1'b0;
    idle_cycles(1);
    chk("R7", "disabled enables", 32'({tx_ch_en, rx_ch_en}), 0);
    chk("R7", "disabled strobe", 32'(strobe), 0);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R7", "disabled idle", 32'({tx_idle, rx_idle}), 3);
    link_en = 1'b1;
    idle_cycles(1);
    chk("R7", "tx back at start", 32'(tx_ch_en), 32'h4);
    chk("R7", "rx at shadow start", 32'(rx_ch_en), 32'h100);

    // R8 R10: top bank region, wrap at region end with no last flag
    link_en = 1'b0; shadow_en = 1'b0; start_bank = 2'd3;
    wr(9'h0C0, 16'h0004);
    for (int a = 9'h0C1; a <= 9'h0FF; a++) wr(9'(a), 16'h0001);
    wr(9'h1C0, 16'h1000);
    link_en = 1'b1;
    idle_cycles(1);
    chk("R8", "bank3 first entry", 32'(tx_ch_en), 32'h8);
    chk("R5", "rx idle entry", 32'(rx_idle), 1);
    tick(1'b0, 1'b0);
    chk("R10", "second entry", 32'(tx_ch_en), 32'h1);
    for (int k = 0; k < 62; k++) tick(1'b0, 1'b0);
    chk("R10", "final entry", 32'(tx_ch_en), 32'h1);
    tick(1'b0, 1'b0);
    chk("R10", "wrap at region end", 32'(tx_ch_en), 32'h8);

    finish_run();
  end
endmodule